// File: doc/BRIEF.md
# I2C Bus Busy/Free Monitor

This block watches the SDA and SCL wires of a multi-master I2C bus and tells the local master whether it may try to take the bus. Both wires are resynchronised into the local clock domain by a chain of flops. Each synchronised sample is compared with the one before it to find Start and Stop conditions.

Two sticky flags record the last condition seen. `sBit` means a Start has been seen and no Stop since. `pBit` means the last condition was a Stop. The `busFree` output is high when `pBit` is set, or when neither flag is set. Each detected condition also gives a one-cycle event pulse. Software can use the Stop pulse as the interrupt that says a busy bus has just been released.

Clearing the module enable wipes both flags and keeps them clear. The synchronisers keep sampling while the module is disabled, so turning it back on does not report a stale edge.

Top module: `bus_state_monitor`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `sBit`, `pBit`, `startEvt` and `stopEvt` are 0 and `busFree` is 1.
- R2: A clock edge that samples `enable` low clears `sBit` and `pBit`. No event pulses while the module is disabled, whatever the bus does. After re-enabling on a quiet bus, no event is reported.
- R3: `sBit` and `pBit` are never both 1. `busFree` is 1 exactly when `pBit` is 1 or both flags are 0.
- R4: A Start is SDA going from 1 to 0 between two consecutive synchronised samples while SCL is 1 in both samples. It sets `sBit`, clears `pBit`, and pulses `startEvt` high for one cycle.
- R5: A Stop is SDA going from 0 to 1 between two consecutive synchronised samples while SCL is 1 in both samples. It sets `pBit`, clears `sBit`, and pulses `stopEvt` high for one cycle. This happens even when the bus was not marked busy.
- R6: A Start detected while `sBit` is already 1 (a repeated Start) pulses `startEvt` again, and `sBit` stays 1.
- R7: A level applied to `sdaIn`/`sclIn` before clock edge n takes effect on the flags and events right after edge n+2, with the default two synchronizer stages.
- R8: SDA changes while SCL is 0 in either sample produce no event and leave both flags unchanged.
- R9: If SDA and SCL change in the same synchronised sample, no event is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; low clears and holds the flags |
| sdaIn | input | 1 | Raw SDA level from the pad |
| sclIn | input | 1 | Raw SCL level from the pad |
| sBit | output | 1 | Sticky flag: Start seen, no Stop since |
| pBit | output | 1 | Sticky flag: Stop was the last condition |
| busFree | output | 1 | High when this master may claim the bus |
| startEvt | output | 1 | One-cycle pulse per detected Start or repeated Start |
| stopEvt | output | 1 | One-cycle pulse per detected Stop |

## Verification
A disable can arrive in the same cycle as a detected Start or Stop. In that case the clear must win: no event pulse and both flags at 0. The bench provokes this by pulling `enable` low in the cycle the detection becomes due. It does this both in directed sequences and in random traffic where `enable` sometimes drops. A second overlap is an SDA edge that lands in the same sample as an SCL change; this must not count as a condition. Every cycle is compared against a reference model in the bench, which follows the sample latency and the detection rules stated above.

// File: rtl/busmon_pkg.sv
package busmon_pkg;
  // Strobes passed from the control decoder to the datapath registers.
  typedef struct packed {
    logic clearAll;
    logic startSeen;
    logic stopSeen;
  } busStrobes_t;

  localparam int unsigned LINE_SDA = 0;
  localparam int unsigned LINE_SCL = 1;
  localparam int unsigned NUM_LINES = 2;
endpackage

// File: rtl/busmon_datapath.sv
module busmon_datapath
  import busmon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sdaRaw,
  input  logic        sclRaw,
  input  busStrobes_t strobes,
  output logic        sdaNow,
  output logic        sclNow,
  output logic        sdaPrev,
  output logic        sclPrev,
  output logic        sBit,
  output logic        pBit,
  output logic        startEvt,
  output logic        stopEvt
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [NUM_LINES-1:0] rawLines;
  logic [NUM_LINES-1:0] syncChain [SYNC_STAGES];
  logic [NUM_LINES-1:0] prevLines;

  assign rawLines[LINE_SDA] = sdaRaw;
  assign rawLines[LINE_SCL] = sclRaw;

  // Synchronizer stages; an idle I2C bus rests high, so reset to 1.
  for (genvar st = 0; st < SYNC_STAGES; st++) begin : g_stage
    if (st == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[st] <= '1;
        else       syncChain[st] <= rawLines;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[st] <= '1;
        else       syncChain[st] <= syncChain[st-1];
      end
    end
  end

  // The previous sample keeps updating while disabled, so no stale edge on re-enable.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLines <= '1;
    else       prevLines <= syncChain[LAST];
  end

  assign sdaNow  = syncChain[LAST][LINE_SDA];
  assign sclNow  = syncChain[LAST][LINE_SCL];
  assign sdaPrev = prevLines[LINE_SDA];
  assign sclPrev = prevLines[LINE_SCL];

  // Sticky flags: clear has priority, then Start, then Stop.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sBit <= 1'b0;
      pBit <= 1'b0;
    end else if (strobes.clearAll) begin
      sBit <= 1'b0;
      pBit <= 1'b0;
    end else if (strobes.startSeen) begin
      sBit <= 1'b1;
      pBit <= 1'b0;
    end else if (strobes.stopSeen) begin
      sBit <= 1'b0;
      pBit <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startEvt <= 1'b0;
      stopEvt  <= 1'b0;
    end else begin
      startEvt <= strobes.startSeen & ~strobes.clearAll;
      stopEvt  <= strobes.stopSeen & ~strobes.clearAll;
    end
  end

  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(sBit && pBit));

  assert_disable_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> (!sBit && !pBit && !startEvt && !stopEvt));

  assert_start_marks_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    startEvt |-> (sBit && !pBit));

  assert_stop_marks_free_R5: assert property (@(posedge clk) disable iff (!rstN)
    stopEvt |-> (pBit && !sBit));

  assert_s_rises_on_start_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sBit) |-> startEvt);

  assert_p_rises_on_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pBit) |-> stopEvt);

  assert_start_single_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    startEvt |=> !startEvt);
endmodule

// File: rtl/busmon_control.sv
module busmon_control
  import busmon_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        sdaNow,
  input  logic        sclNow,
  input  logic        sdaPrev,
  input  logic        sclPrev,
  output busStrobes_t strobes
);
  logic sclHeldHigh;
  logic sdaFell;
  logic sdaRose;

  // SCL must be high in both samples; an SCL change in the same sample disqualifies the edge.
  assign sclHeldHigh = sclNow & sclPrev;
  assign sdaFell     = sdaPrev & ~sdaNow;
  assign sdaRose     = ~sdaPrev & sdaNow;

  always_comb begin
    strobes           = '0;
    strobes.clearAll  = ~enable;
    strobes.startSeen = enable & sclHeldHigh & sdaFell;
    strobes.stopSeen  = enable & sclHeldHigh & sdaRose;
  end

  assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.startSeen && strobes.stopSeen));

  assert_no_strobe_scl_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!sclNow || !sclPrev) |-> !(strobes.startSeen || strobes.stopSeen));
endmodule

// File: rtl/bus_state_monitor.sv
module bus_state_monitor
  import busmon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic sdaIn,
  input  logic sclIn,
  output logic sBit,
  output logic pBit,
  output logic busFree,
  output logic startEvt,
  output logic stopEvt
);
  busStrobes_t strobes;
  logic sdaNow, sclNow, sdaPrev, sclPrev;

  busmon_control i_control (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .sdaNow  (sdaNow),
    .sclNow  (sclNow),
    .sdaPrev (sdaPrev),
    .sclPrev (sclPrev),
    .strobes (strobes)
  );

  busmon_datapath #(.SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .sdaRaw   (sdaIn),
    .sclRaw   (sclIn),
    .strobes  (strobes),
    .sdaNow   (sdaNow),
    .sclNow   (sclNow),
    .sdaPrev  (sdaPrev),
    .sclPrev  (sclPrev),
    .sBit     (sBit),
    .pBit     (pBit),
    .startEvt (startEvt),
    .stopEvt  (stopEvt)
  );

  assign busFree = pBit | ~(sBit | pBit);

  assert_free_when_not_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    busFree == !sBit);
endmodule

// File: tb/test_bus_state_monitor.sv
`timescale 1ns/1ps
module test_bus_state_monitor;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic sdaIn = 1'b1;
  logic sclIn = 1'b1;
  logic sBit, pBit, busFree, startEvt, stopEvt;

  int vectors = 0;
  int miscompares = 0;

  // Reference model: m0/m1 follow the synchronizer stages, m2 the previous sample.
  logic mSda0 = 1, mSda1 = 1, mSda2 = 1;
  logic mScl0 = 1, mScl1 = 1, mScl2 = 1;
  logic eS = 0, eP = 0, eStart = 0, eStop = 0;

  always #2.5 clk = ~clk;

  bus_state_monitor i_bus_state_monitor (
    .clk(clk), .rstN(rstN), .enable(enable), .sdaIn(sdaIn), .sclIn(sclIn),
    .sBit(sBit), .pBit(pBit), .busFree(busFree), .startEvt(startEvt), .stopEvt(stopEvt)
  );

  function automatic logic expFree(logic s, logic p);
    return p | (~s & ~p);
  endfunction

  task automatic compare(string req);
    vectors++;
    if ({sBit, pBit, busFree, startEvt, stopEvt} !==
        {eS, eP, expFree(eS, eP), eStart, eStop}) begin
      miscompares++;
      $display("FAIL %s: got s=%b p=%b free=%b start=%b stop=%b, expected s=%b p=%b free=%b start=%b stop=%b",
               req, sBit, pBit, busFree, startEvt, stopEvt,
               eS, eP, expFree(eS, eP), eStart, eStop);
    end
  endtask

  task automatic modelEdge(logic en, logic sdaV, logic sclV);
    logic st, sp;
    st = en & mScl1 & mScl2 & mSda2 & ~mSda1;
    sp = en & mScl1 & mScl2 & ~mSda2 & mSda1;
    if (!en) begin eS = 0; eP = 0; end
    else if (st) begin eS = 1; eP = 0; end
    else if (sp) begin eS = 0; eP = 1; end
    eStart = st; eStop = sp;
    mSda2 = mSda1; mSda1 = mSda0; mSda0 = sdaV;
    mScl2 = mScl1; mScl1 = mScl0; mScl0 = sclV;
  endtask

  task automatic step(logic sdaV, logic sclV, logic en, string req);
    @(negedge clk);
    sdaIn = sdaV; sclIn = sclV; enable = en;
    @(posedge clk);
    #1;
    modelEdge(en, sdaV, sclV);
    compare(req);
  endtask

  task automatic hold(int n, string req);
    for (int i = 0; i < n; i++) step(sdaIn, sclIn, enable, req);
  endtask

  task automatic expectBit(logic act, logic exp, string req, string what);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: %s got %b expected %b", req, what, act, exp);
    end
  endtask

  initial begin : watchdog
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    logic nSda, nScl, nEn;
    int r;
    void'($urandom(32'd1977));
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 compare("R1");
    @(negedge clk); rstN = 1'b1; enable = 1'b1;
    @(posedge clk); #1;
    modelEdge(1'b1, 1'b1, 1'b1);
    compare("R1");
    hold(3, "R1");

    // R4 + R7: Start, check exact latency
    @(negedge clk); sdaIn = 1'b0;
    @(posedge clk); #1; modelEdge(1'b1, 1'b0, 1'b1);
    expectBit(startEvt, 1'b0, "R7", "startEvt after 1 edge");
    @(posedge clk); #1; modelEdge(1'b1, 1'b0, 1'b1);
    expectBit(startEvt, 1'b0, "R7", "startEvt after 2 edges");
    @(posedge clk); #1; modelEdge(1'b1, 1'b0, 1'b1);
    expectBit(startEvt, 1'b1, "R7", "startEvt after 3 edges");
    compare("R4");
    hold(3, "R4");
    expectBit(sBit, 1'b1, "R4", "sBit sticky");
    expectBit(busFree, 1'b0, "R3", "busFree while busy");

    // R8: data toggles with SCL low
    step(1'b0, 1'b0, 1'b1, "R8");
    step(1'b1, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b0, 1'b1, "R8");
    step(1'b1, 1'b0, 1'b1, "R8");
    hold(4, "R8");
    expectBit(sBit, 1'b1, "R8", "sBit kept with SCL low");

    // R6: repeated Start (SDA already 1, SCL goes high, then SDA falls)
    step(1'b1, 1'b1, 1'b1, "R6");
    hold(3, "R6");
    step(1'b0, 1'b1, 1'b1, "R6");
    hold(1, "R6");
    step(1'b0, 1'b1, 1'b1, "R6");
    expectBit(startEvt, 1'b1, "R6", "repeated start pulse");
    expectBit(sBit, 1'b1, "R6", "sBit held on repeated start");
    hold(2, "R6");

    // R5: Stop
    step(1'b1, 1'b1, 1'b1, "R5");
    hold(2, "R5");
    expectBit(stopEvt, 1'b1, "R5", "stop pulse");
    hold(1, "R5");
    expectBit(stopEvt, 1'b0, "R5", "stop pulse one cycle");
    expectBit(pBit, 1'b1, "R5", "pBit sticky");
    expectBit(busFree, 1'b1, "R3", "busFree after stop");

    // R9: SDA and SCL change in the same sample
    step(1'b0, 1'b0, 1'b1, "R9");
    hold(4, "R9");
    expectBit(startEvt | stopEvt, 1'b0, "R9", "no event on simultaneous change");
    step(1'b1, 1'b1, 1'b1, "R9");
    hold(4, "R9");
    expectBit(pBit, 1'b1, "R9", "pBit untouched");

    // R2: disable in the cycle the Start detection falls due
    step(1'b0, 1'b1, 1'b1, "R2");
    hold(1, "R2");
    step(1'b0, 1'b1, 1'b0, "R2");
    expectBit(startEvt, 1'b0, "R2", "start suppressed by disable");
    expectBit(sBit, 1'b0, "R2", "sBit cleared by disable");
    step(1'b1, 1'b1, 1'b0, "R2");
    hold(4, "R2");
    expectBit(stopEvt, 1'b0, "R2", "stop suppressed while disabled");
    step(1'b1, 1'b1, 1'b1, "R2");
    hold(4, "R2");
    expectBit(startEvt | stopEvt, 1'b0, "R2", "no stale edge on re-enable");

    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      r = $urandom_range(0, 99);
      nSda = sdaIn; nScl = sclIn; nEn = enable;
      if (r < 35) nSda = ~sdaIn;
      else if (r < 65) nScl = ~sclIn;
      else if (r < 70) begin nSda = ~sdaIn; nScl = ~sclIn; end
      if ($urandom_range(0, 99) < 4) nEn = ~enable;
      if (!nEn && $urandom_range(0, 3) == 0) nEn = 1'b1;
      step(nSda, nScl, nEn, "R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule